// File: doc/BRIEF.md
# Long-Latency Integer Operation Reuse Unit

This unit sits in front of a multi-cycle integer arithmetic engine (add, subtract, multiply, unsigned divide). Each accepted operation carries an opcode, two operands and a checkpoint tag. Three paths work on it. A combinational detector recognises operand patterns whose answer is known without arithmetic and returns that answer one cycle later. A small fully associative store of recent non-trivial results is searched and, on a match, answers in two cycles. The slow engine is started as soon as the operation is known to be non-trivial.

The fastest path that succeeds produces the result. A store hit raises an abort to the slow engine. Results computed by the slow engine are written into the store. Trivial operations never enter it, so its few entries are kept for values worth remembering. When a checkpoint is squashed, the stored entries tagged with it become the preferred victims for the next insertion.

Top module: `lat_reuse_unit`

## Requirements
- R1: After reset `in_ready`=1, `out_valid`=0 and `slow_start`=0. An operation is taken when `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after a non-trivial operation is taken until its result is reported. Opcodes: 0=add, 1=subtract, 2=multiply, 3=unsigned divide. Source codes on `out_src`: 1=trivial, 2=stored, 3=computed.
- R2: The following add and subtract patterns are trivial: x+0 gives x, 0+x gives x, x−0 gives x, x−x gives 0. `out_valid` rises in the first cycle after acceptance with `out_src`=1.
- R3: The following multiply patterns are trivial: x×0 and 0×x give 0, x×1 gives x, 1×x gives x. They are reported in the same way as in R2.
- R4: The following divide patterns are trivial: x/1 gives x, 0/x (x≠0) gives 0, x/x (x≠0) gives 1. They are reported in the same way as in R2.
- R5: Division by zero, including 0/0, is trivial. It returns all ones with `out_dz`=1. For every other result `out_dz` is 0.
- R6: Operand equality counts only for subtract and divide. 0−x with x≠0 is not trivial. x+x and x×x with x not 0 or 1 go to the slow engine.
- R7: A trivial operation neither pulses `slow_start` nor takes a store entry. Stored entries survive any number of trivial operations.
- R8: A non-trivial operation that misses in the store pulses `slow_start` for one cycle in the cycle after acceptance, with `slow_op`/`slow_a`/`slow_b` valid. The result is reported with `out_src`=3 in the cycle after `slow_done`.
- R9: A repeat of a computed operation with identical opcode, operand A and operand B is reported with `out_src`=3 replaced by `out_src`=2 in the second cycle after acceptance. `slow_abort` pulses in that same cycle, so the slow engine never completes it. A different opcode, or swapped operands, misses.
- R10: The store holds 4 entries. An insertion takes the lowest-index empty entry first. If there is none, it takes the lowest-index entry whose checkpoint was squashed through `fold_valid`/`fold_cp`. Otherwise it takes a round-robin pointer that starts at entry 0 and advances only when it is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation can be taken |
| in_op | input | 2 | Opcode |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| in_cp | input | CPW | Checkpoint tag of the operation |
| fold_valid | input | 1 | A checkpoint is squashed this cycle |
| fold_cp | input | CPW | Tag of the squashed checkpoint |
| slow_start | output | 1 | Start pulse to slow engine |
| slow_abort | output | 1 | Abort pulse to slow engine |
| slow_op | output | 2 | Opcode to slow engine |
| slow_a | output | W | Operand A to slow engine |
| slow_b | output | W | Operand B to slow engine |
| slow_done | input | 1 | Slow engine result valid |
| slow_result | input | W | Slow engine result |
| out_valid | output | 1 | Result pulse |
| out_result | output | W | Result value |
| out_src | output | 2 | Which path produced the result |
| out_dz | output | 1 | Division by zero flag |

## Verification
The hardest state to reach from the ports is a full store that holds a mix of squashed and live entries with the round-robin pointer still untouched. Only that state separates the three levels of victim choice. The bench resets, fills all four entries with computed multiplies under four distinct checkpoint tags, and squashes one tag. It then inserts a fifth operation and probes every original operation to see which one was lost. Two further misses then show the pointer stepping from entry 0 to entry 1.

// File: rtl/lru_pkg.sv
`timescale 1ns/1ps
package lru_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_DIV = 2'd3} op_e;
  typedef enum logic [1:0] {SRC_NONE = 2'd0, SRC_TRIV = 2'd1, SRC_CACHE = 2'd2, SRC_COMP = 2'd3} src_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_LOOK = 2'd1, ST_WAIT = 2'd2} st_e;
endpackage

// File: rtl/lru_trivial.sv
`timescale 1ns/1ps
module lru_trivial
  import lru_pkg::*;
#(
  parameter int W = 16
) (
  input  op_e          op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         hit,
  output logic [W-1:0] res,
  output logic         dz
);
  logic a_z, b_z, a_one, b_one, same;
  assign a_z   = (a == '0);
  assign b_z   = (b == '0);
  assign a_one = (a == W'(1));
  assign b_one = (b == W'(1));
  assign same  = (a == b);

  always_comb begin
    hit = 1'b0;
    res = '0;
    dz  = 1'b0;
    case (op)
      OP_ADD: begin
        if (b_z)      begin hit = 1'b1; res = a; end
        else if (a_z) begin hit = 1'b1; res = b; end
      end
      OP_SUB: begin
        if (b_z)       begin hit = 1'b1; res = a; end
        else if (same) begin hit = 1'b1; res = '0; end
      end
      OP_MUL: begin
        if (a_z || b_z) begin hit = 1'b1; res = '0; end
        else if (b_one) begin hit = 1'b1; res = a; end
        else if (a_one) begin hit = 1'b1; res = b; end
      end
      default: begin
        if (b_z)        begin hit = 1'b1; res = '1; dz = 1'b1; end
        else if (b_one) begin hit = 1'b1; res = a; end
        else if (a_z)   begin hit = 1'b1; res = '0; end
        else if (same)  begin hit = 1'b1; res = W'(1); end
      end
    endcase
  end
endmodule

// File: rtl/lru_cache.sv
`timescale 1ns/1ps
module lru_cache
  import lru_pkg::*;
#(
  parameter int W       = 16,
  parameter int CPW     = 3,
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  op_e                lk_op,
  input  logic [W-1:0]       lk_a,
  input  logic [W-1:0]       lk_b,
  output logic [ENTRIES-1:0] hit_vec,
  output logic               hit,
  output logic [W-1:0]       hit_data,
  input  logic               wr_en,
  input  op_e                wr_op,
  input  logic [W-1:0]       wr_a,
  input  logic [W-1:0]       wr_b,
  input  logic [W-1:0]       wr_data,
  input  logic [CPW-1:0]     wr_cp,
  input  logic               fold_valid,
  input  logic [CPW-1:0]     fold_cp
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, cand_q;
  op_e                tag_op [ENTRIES];
  logic [W-1:0]       tag_a  [ENTRIES];
  logic [W-1:0]       tag_b  [ENTRIES];
  logic [W-1:0]       dat    [ENTRIES];
  logic [CPW-1:0]     ent_cp [ENTRIES];
  logic [IW-1:0]      rr_q, victim;
  logic               use_rr;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = vld_q[g] && (tag_op[g] == lk_op) &&
                        (tag_a[g] == lk_a) && (tag_b[g] == lk_b);
  end
  assign hit = |hit_vec;

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_data = hit_data | dat[i];
  end

  always_comb begin
    logic got_inv, got_cand;
    got_inv  = 1'b0;
    got_cand = 1'b0;
    victim   = rr_q;
    for (int i = 0; i < ENTRIES; i++)
      if (!got_inv && !vld_q[i]) begin victim = IW'(i); got_inv = 1'b1; end
    for (int i = 0; i < ENTRIES; i++)
      if (!got_inv && !got_cand && cand_q[i]) begin victim = IW'(i); got_cand = 1'b1; end
    use_rr = !got_inv && !got_cand;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      cand_q <= '0;
      rr_q   <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (fold_valid && vld_q[i] && ent_cp[i] == fold_cp) cand_q[i] <= 1'b1;
      if (wr_en) begin
        vld_q[victim]  <= 1'b1;
        cand_q[victim] <= fold_valid && (fold_cp == wr_cp);
        if (use_rr) rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_op[victim] <= wr_op;
      tag_a[victim]  <= wr_a;
      tag_b[victim]  <= wr_b;
      dat[victim]    <= wr_data;
      ent_cp[victim] <= wr_cp;
    end
  end
endmodule

// File: rtl/lat_reuse_unit.sv
`timescale 1ns/1ps
module lat_reuse_unit
  import lru_pkg::*;
#(
  parameter int W       = 16,
  parameter int CPW     = 3,
  parameter int ENTRIES = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [1:0]     in_op,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic [CPW-1:0] in_cp,
  input  logic           fold_valid,
  input  logic [CPW-1:0] fold_cp,
  output logic           slow_start,
  output logic           slow_abort,
  output logic [1:0]     slow_op,
  output logic [W-1:0]   slow_a,
  output logic [W-1:0]   slow_b,
  input  logic           slow_done,
  input  logic [W-1:0]   slow_result,
  output logic           out_valid,
  output logic [W-1:0]   out_result,
  output logic [1:0]     out_src,
  output logic           out_dz
);
  st_e                state_q;
  op_e                op_q;
  logic [W-1:0]       a_q, b_q;
  logic [CPW-1:0]     cp_q;
  logic               accept;
  logic               tv_hit, tv_dz;
  logic [W-1:0]       tv_res;
  logic               c_hit, c_wr;
  logic [W-1:0]       c_data;
  logic [ENTRIES-1:0] hit_vec;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign slow_op  = op_q;
  assign slow_a   = a_q;
  assign slow_b   = b_q;

  lru_trivial #(.W(W)) u_triv (
    .op(op_e'(in_op)), .a(in_a), .b(in_b),
    .hit(tv_hit), .res(tv_res), .dz(tv_dz)
  );

  assign c_wr = slow_done &&
                ((state_q == ST_WAIT) || (state_q == ST_LOOK && !c_hit));

  lru_cache #(.W(W), .CPW(CPW), .ENTRIES(ENTRIES)) u_cache (
    .clk(clk), .rst(rst),
    .lk_op(op_q), .lk_a(a_q), .lk_b(b_q),
    .hit_vec(hit_vec), .hit(c_hit), .hit_data(c_data),
    .wr_en(c_wr), .wr_op(op_q), .wr_a(a_q), .wr_b(b_q),
    .wr_data(slow_result), .wr_cp(cp_q),
    .fold_valid(fold_valid), .fold_cp(fold_cp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_ADD;
      a_q        <= '0;
      b_q        <= '0;
      cp_q       <= '0;
      slow_start <= 1'b0;
      slow_abort <= 1'b0;
      out_valid  <= 1'b0;
      out_result <= '0;
      out_src    <= SRC_NONE;
      out_dz     <= 1'b0;
    end else begin
      slow_start <= 1'b0;
      slow_abort <= 1'b0;
      out_valid  <= 1'b0;
      out_dz     <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          if (tv_hit) begin
            out_valid  <= 1'b1;
            out_result <= tv_res;
            out_src    <= SRC_TRIV;
            out_dz     <= tv_dz;
          end else begin
            op_q       <= op_e'(in_op);
            a_q        <= in_a;
            b_q        <= in_b;
            cp_q       <= in_cp;
            slow_start <= 1'b1;
            state_q    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (c_hit) begin
            out_valid  <= 1'b1;
            out_result <= c_data;
            out_src    <= SRC_CACHE;
            slow_abort <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (slow_done) begin
            out_valid  <= 1'b1;
            out_result <= slow_result;
            out_src    <= SRC_COMP;
            state_q    <= ST_IDLE;
          end else begin
            state_q    <= ST_WAIT;
          end
        end
        default: if (slow_done) begin
          out_valid  <= 1'b1;
          out_result <= slow_result;
          out_src    <= SRC_COMP;
          state_q    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lru_checker.sv
`timescale 1ns/1ps
module lru_checker
  import lru_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic [1:0]         out_src,
  input logic               out_dz,
  input logic               slow_start,
  input logic               slow_abort,
  input logic               slow_done,
  input logic [ENTRIES-1:0] hit_vec
);
  AST_TRIV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_src == SRC_TRIV) |-> $past(in_valid && in_ready)); // R2
  AST_DZ_ONLY_TRIV: assert property (@(posedge clk) disable iff (rst)
    out_dz |-> (out_valid && out_src == SRC_TRIV)); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    slow_start |=> !slow_start); // R8
  AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    slow_start |-> $past(in_valid && in_ready)); // R7
  AST_COMP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_src == SRC_COMP) |-> $past(slow_done)); // R8
  AST_HIT_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_src == SRC_CACHE) |-> $past(slow_start)); // R9
  AST_ABORT_WITH_HIT: assert property (@(posedge clk) disable iff (rst)
    slow_abort |-> (out_valid && out_src == SRC_CACHE)); // R9
  AST_UNIQUE_TAGS: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec)); // R10
endmodule

bind lat_reuse_unit lru_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_src(out_src), .out_dz(out_dz),
  .slow_start(slow_start), .slow_abort(slow_abort), .slow_done(slow_done),
  .hit_vec(hit_vec)
);

// File: tb/lat_reuse_unit_test.sv
`timescale 1ns/1ps
module lat_reuse_unit_test;
  localparam int W = 16, CPW = 3, LAT = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, fold_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic [CPW-1:0] in_cp = '0, fold_cp = '0;
  logic in_ready, slow_start, slow_abort, slow_done, out_valid, out_dz;
  logic [1:0] slow_op, out_src;
  logic [W-1:0] slow_a, slow_b, slow_result, out_result;

  int checks = 0, errors = 0, starts_n = 0, dones_n = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lat_reuse_unit #(.W(W), .CPW(CPW), .ENTRIES(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_cp(in_cp),
    .fold_valid(fold_valid), .fold_cp(fold_cp),
    .slow_start(slow_start), .slow_abort(slow_abort), .slow_op(slow_op),
    .slow_a(slow_a), .slow_b(slow_b), .slow_done(slow_done),
    .slow_result(slow_result), .out_valid(out_valid), .out_result(out_result),
    .out_src(out_src), .out_dz(out_dz)
  );

  // slow engine model
  logic m_busy = 1'b0;
  int m_cnt = 0;
  logic [1:0] m_op;
  logic [W-1:0] m_a, m_b;
  function automatic logic [W-1:0] calc(input logic [1:0] op, input logic [W-1:0] a, b);
    logic [2*W-1:0] p;
    p = a * b;
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return p[W-1:0];
      default: return (b != 0) ? a / b : '1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 1'b0; slow_done <= 1'b0; slow_result <= '0;
    end else begin
      slow_done <= 1'b0;
      if (slow_start) starts_n <= starts_n + 1;
      if (slow_abort) m_busy <= 1'b0;
      else if (slow_start) begin
        m_busy <= 1'b1; m_cnt <= LAT; m_op <= slow_op; m_a <= slow_a; m_b <= slow_b;
      end else if (m_busy) begin
        if (m_cnt == 1) begin
          slow_done <= 1'b1; slow_result <= calc(m_op, m_a, m_b);
          m_busy <= 1'b0; dones_n <= dones_n + 1;
        end
        m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0; fold_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [W-1:0] a, b, input logic [CPW-1:0] cp,
                        output logic [W-1:0] r, output logic [1:0] s, output logic dz,
                        output logic ab, output int n);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_cp = cp;
    @(negedge clk);
    in_valid = 1'b0; n = 1;
    while (!out_valid && n < 200) begin @(negedge clk); n++; end
    r = out_result; s = out_src; dz = out_dz; ab = slow_abort;
  endtask

  task automatic op_check(input logic [1:0] op, input logic [W-1:0] a, b, input logic [CPW-1:0] cp,
                          input logic [W-1:0] er, input logic [1:0] es, input logic edz, input string req);
    logic [W-1:0] r; logic [1:0] s; logic dz, ab; int n; bit lat_ok;
    run_op(op, a, b, cp, r, s, dz, ab, n);
    chk(r == er, {req, " result"}, 32'(r), 32'(er));
    chk(s == es, {req, " source"}, 32'(s), 32'(es));
    chk(dz == edz, {req, " dz flag"}, 32'(dz), 32'(edz));
    lat_ok = (es == 2'd3) ? (n > 2) : (n == int'(es));
    chk(lat_ok, {req, " latency"}, 32'(n), (es == 2'd3) ? 32'd3 : 32'(es));
    if (es == 2'd2) chk(ab == 1'b1, {req, " abort with hit"}, 32'(ab), 32'd1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(in_ready == 1'b1, "R1 ready after reset", 32'(in_ready), 32'd1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk(slow_start == 1'b0, "R1 start after reset", 32'(slow_start), 32'd0);
  endtask

  task automatic t_addsub();
    int s0;
    s0 = starts_n;
    op_check(2'd0, 16'd1234, 16'd0, 3'd0, 16'd1234, 2'd1, 1'b0, "R2 x+0");
    op_check(2'd0, 16'd0, 16'd77, 3'd0, 16'd77, 2'd1, 1'b0, "R2 0+x");
    op_check(2'd1, 16'd55, 16'd0, 3'd0, 16'd55, 2'd1, 1'b0, "R2 x-0");
    op_check(2'd1, 16'd900, 16'd900, 3'd0, 16'd0, 2'd1, 1'b0, "R2 x-x");
    @(negedge clk);
    chk(starts_n == s0, "R7 no start for trivial add/sub", 32'(starts_n), 32'(s0));
  endtask

  task automatic t_mul();
    op_check(2'd2, 16'h1234, 16'd0, 3'd0, 16'd0, 2'd1, 1'b0, "R3 x*0");
    op_check(2'd2, 16'd0, 16'd9, 3'd0, 16'd0, 2'd1, 1'b0, "R3 0*x");
    op_check(2'd2, 16'd321, 16'd1, 3'd0, 16'd321, 2'd1, 1'b0, "R3 x*1");
    op_check(2'd2, 16'd1, 16'd4000, 3'd0, 16'd4000, 2'd1, 1'b0, "R3 1*x");
  endtask

  task automatic t_div();
    op_check(2'd3, 16'd500, 16'd1, 3'd0, 16'd500, 2'd1, 1'b0, "R4 x/1");
    op_check(2'd3, 16'd0, 16'd37, 3'd0, 16'd0, 2'd1, 1'b0, "R4 0/x");
    op_check(2'd3, 16'd613, 16'd613, 3'd0, 16'd1, 2'd1, 1'b0, "R4 x/x");
    op_check(2'd3, 16'd42, 16'd0, 3'd0, 16'hFFFF, 2'd1, 1'b1, "R5 x/0");
    op_check(2'd3, 16'd0, 16'd0, 3'd0, 16'hFFFF, 2'd1, 1'b1, "R5 0/0");
  endtask

  task automatic t_equality();
    op_check(2'd1, 16'd0, 16'd5, 3'd1, 16'hFFFB, 2'd3, 1'b0, "R6 0-x computed");
    op_check(2'd0, 16'd300, 16'd300, 3'd1, 16'd600, 2'd3, 1'b0, "R6 x+x computed");
    op_check(2'd2, 16'd7, 16'd7, 3'd1, 16'd49, 2'd3, 1'b0, "R6 x*x computed");
  endtask

  task automatic t_reuse();
    int d0;
    do_reset();
    op_check(2'd2, 16'd13, 16'd17, 3'd2, 16'd221, 2'd3, 1'b0, "R8 mul miss");
    d0 = dones_n;
    op_check(2'd2, 16'd13, 16'd17, 3'd2, 16'd221, 2'd2, 1'b0, "R9 mul hit");
    repeat (LAT + 4) @(negedge clk);
    chk(dones_n == d0, "R9 aborted engine never completes", 32'(dones_n), 32'(d0));
    op_check(2'd3, 16'd1000, 16'd7, 3'd2, 16'd142, 2'd3, 1'b0, "R8 div miss");
    op_check(2'd3, 16'd1000, 16'd7, 3'd2, 16'd142, 2'd2, 1'b0, "R9 div hit");
    op_check(2'd0, 16'd13, 16'd17, 3'd2, 16'd30, 2'd3, 1'b0, "R9 opcode in tag");
    op_check(2'd2, 16'd17, 16'd13, 3'd2, 16'd221, 2'd3, 1'b0, "R9 operand order in tag");
  endtask

  task automatic fill4();
    op_check(2'd2, 16'd2, 16'd3, 3'd0, 16'd6, 2'd3, 1'b0, "R10 fill A");
    op_check(2'd2, 16'd2, 16'd5, 3'd1, 16'd10, 2'd3, 1'b0, "R10 fill B");
    op_check(2'd2, 16'd3, 16'd5, 3'd2, 16'd15, 2'd3, 1'b0, "R10 fill C");
    op_check(2'd2, 16'd3, 16'd7, 3'd3, 16'd21, 2'd3, 1'b0, "R10 fill D");
  endtask

  task automatic t_filter();
    int s0;
    do_reset();
    fill4();
    s0 = starts_n;
    for (int i = 2; i < 8; i++)
      op_check(2'd2, 16'(i * 11), 16'd1, 3'd4, 16'(i * 11), 2'd1, 1'b0, "R7 trivial burst");
    @(negedge clk);
    chk(starts_n == s0, "R7 trivial never starts engine", 32'(starts_n), 32'(s0));
    op_check(2'd2, 16'd2, 16'd3, 3'd0, 16'd6, 2'd2, 1'b0, "R7 A survives");
    op_check(2'd2, 16'd2, 16'd5, 3'd1, 16'd10, 2'd2, 1'b0, "R7 B survives");
    op_check(2'd2, 16'd3, 16'd5, 3'd2, 16'd15, 2'd2, 1'b0, "R7 C survives");
    op_check(2'd2, 16'd3, 16'd7, 3'd3, 16'd21, 2'd2, 1'b0, "R7 D survives");
  endtask

  task automatic t_replace();
    do_reset();
    fill4();
    @(negedge clk);
    fold_valid = 1'b1; fold_cp = 3'd2;
    @(negedge clk);
    fold_valid = 1'b0;
    op_check(2'd2, 16'd5, 16'd7, 3'd5, 16'd35, 2'd3, 1'b0, "R10 insert E");
    op_check(2'd2, 16'd2, 16'd3, 3'd0, 16'd6, 2'd2, 1'b0, "R10 A kept");
    op_check(2'd2, 16'd2, 16'd5, 3'd1, 16'd10, 2'd2, 1'b0, "R10 B kept");
    op_check(2'd2, 16'd3, 16'd7, 3'd3, 16'd21, 2'd2, 1'b0, "R10 D kept");
    op_check(2'd2, 16'd5, 16'd7, 3'd5, 16'd35, 2'd2, 1'b0, "R10 E stored");
    op_check(2'd2, 16'd3, 16'd5, 3'd6, 16'd15, 2'd3, 1'b0, "R10 folded C evicted");
    op_check(2'd2, 16'd2, 16'd3, 3'd6, 16'd6, 2'd3, 1'b0, "R10 round-robin evicted A");
    op_check(2'd2, 16'd2, 16'd5, 3'd6, 16'd10, 2'd3, 1'b0, "R10 pointer advanced to B");
    op_check(2'd2, 16'd3, 16'd7, 3'd3, 16'd21, 2'd2, 1'b0, "R10 D still kept");
  endtask

  initial begin
    t_reset();
    t_addsub();
    t_mul();
    t_div();
    t_equality();
    t_reuse();
    t_filter();
    t_replace();
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #750000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule